// File: doc/BRIEF.md
# Virtual Interrupt List-Entry Controller

This block keeps a small file of virtual interrupt entries for one virtual CPU. A hypervisor programs each entry through a register port: its state, its priority, its virtual ID, a flag that links it to a physical interrupt with a physical ID, and a flag that asks for maintenance when the entry completes. The guest side has three operations. Acknowledge picks the best pending entry and returns its virtual ID. End-of-interrupt drops the running priority. Deactivate retires an active entry. These operations run in one of two modes. In combined mode, end-of-interrupt both drops the priority and retires the entry. In split mode, retirement waits for a separate deactivate write.

From the entry states the block decodes a per-entry completion status vector. It holds no stored copy of that vector. A holdoff timer gates the maintenance interrupt, so the guest can finish several interrupts before the hypervisor is called, and the hypervisor then sees all finished entries in one read. Retiring a hardware-linked entry sends a one-cycle pulse to the physical side instead of setting a status bit.

Top module: `vint_lr_ctrl`

## Requirements
- R1: After synchronous reset, every entry is Inactive, the running priority is idle (all ones, 31), `eoi_status` is zero, and `maint_irq`, `g_ack_vld` and `pdeact_vld` are low.
- R2: Entry state uses 2 bits: 00 Inactive, 01 Pending, 10 Active, 11 Pending+Active. Bit i of `eoi_status` is 1 exactly when entry i is Inactive, its hardware-linked flag is clear and its maintenance flag is set. The bit follows the entry state in the same cycle the state register changes.
- R3: On `g_ack`, an entry is eligible if it is Pending (01) and its priority value is below the running priority. The block picks the eligible entry with the lowest priority value, and the lowest index on a tie. On the next cycle `g_ack_vld` is high and `g_ack_id` holds that entry's virtual ID, the entry is Active (10), and `g_rpr` equals its priority.
- R4: When no entry is eligible, the acknowledge returns ID 1023. No entry changes and the running priority is unchanged.
- R5: End-of-interrupt (`g_eoi` with `g_id` not 1023) restores the running priority to the value in force before the latest still-open acknowledge, or to idle. In combined mode (`cfg_split`=0) it also retires the lowest-index entry whose state has bit 1 set and whose virtual ID equals `g_id` (10→00, 11→01). In combined mode `g_dir` has no effect.
- R6: In split mode, end-of-interrupt only drops the priority, and the entry stays Active. A `g_dir` with a matching ID retires the entry as in R5 and leaves the priority alone. Several deactivations may follow several end-of-interrupt writes.
- R7: End-of-interrupt with ID 1023 has no effect.
- R8: Retiring an entry whose hardware-linked flag is set gives `pdeact_vld` high for one cycle on the next cycle, with `pdeact_pid` holding the entry's physical ID. Its status bit stays 0.
- R9: With holdoff H, `maint_irq` rises on the (H+1)th rising edge after `eoi_status` becomes non-zero, and it stays high while the vector is non-zero.
- R10: Several status bits may be set at once and stay set together. `maint_irq` falls on the first edge after the vector becomes zero, and the holdoff count restarts from zero.
- R11: A hypervisor write updates all fields of entry `hv_idx` at the next edge and overrides any guest change to that entry in the same cycle. `hv_rd_state` returns the state of entry `hv_rd_idx` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_split | input | 1 | 1 = separate deactivate, 0 = combined |
| cfg_holdoff | input | HOLD_W | Maintenance holdoff count |
| hv_wr | input | 1 | Entry write strobe |
| hv_idx | input | IDX_W | Entry to write |
| hv_state | input | 2 | State to write |
| hv_hw | input | 1 | Hardware-linked flag |
| hv_maint | input | 1 | Maintenance-on-completion flag |
| hv_pri | input | PRI_W | Priority (lower is more urgent) |
| hv_vid | input | VID_W | Virtual ID |
| hv_pid | input | PID_W | Physical ID |
| hv_rd_idx | input | IDX_W | Entry to read back |
| hv_rd_state | output | 2 | Registered state of the read entry |
| g_ack | input | 1 | Acknowledge request |
| g_eoi | input | 1 | End-of-interrupt write |
| g_dir | input | 1 | Deactivate write |
| g_id | input | VID_W | ID for end-of-interrupt or deactivate |
| g_ack_vld | output | 1 | Acknowledge result valid |
| g_ack_id | output | VID_W | Acknowledged ID or 1023 |
| g_rpr | output | PRI_W | Running priority |
| eoi_status | output | N | Per-entry completion status |
| maint_irq | output | 1 | Maintenance interrupt |
| pdeact_vld | output | 1 | Physical deactivate pulse |
| pdeact_pid | output | PID_W | Physical ID to deactivate |

## Verification
The bench builds the block with its defaults: 16 entries, 5-bit priority, 10-bit IDs and an 8-bit holdoff. It sets the holdoff at run time to 0, 3, 4 and 10. Holdoff 0 reaches the immediate-report edge. The longer values let two or three completions build up before the interrupt fires. The 16-entry file with a 5-bit priority makes priority ties, the nesting limit of the running priority and the idle value 31 easy to reach.

// File: rtl/vint_lr_pkg.sv
package vint_lr_pkg;
  typedef enum logic [1:0] {
    ST_INACT = 2'b00,
    ST_PEND  = 2'b01,
    ST_ACT   = 2'b10,
    ST_PACT  = 2'b11
  } lr_state_e;
endpackage

// File: rtl/vint_lr_select.sv
// Lowest priority value among eligible entries, lowest index on a tie.
module vint_lr_select #(
  parameter int N     = 16,
  parameter int PRI_W = 5,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]       elig,
  input  logic [N*PRI_W-1:0] pri_flat,
  output logic               found,
  output logic [IDX_W-1:0]   sel_idx
);
  logic [PRI_W-1:0] best;

  always_comb begin
    found   = 1'b0;
    sel_idx = '0;
    best    = '1;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && (!found || pri_flat[i*PRI_W +: PRI_W] < best)) begin
        found   = 1'b1;
        sel_idx = IDX_W'(i);
        best    = pri_flat[i*PRI_W +: PRI_W];
      end
    end
  end
endmodule

// File: rtl/vint_lr_match.sv
// Lowest-index active entry whose virtual ID equals the request ID.
module vint_lr_match #(
  parameter int N     = 16,
  parameter int VID_W = 10,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]       active,
  input  logic [N*VID_W-1:0] vid_flat,
  input  logic [VID_W-1:0]   req_id,
  output logic               hit,
  output logic [IDX_W-1:0]   hit_idx
);
  logic [N-1:0] eq;

  for (genvar gi = 0; gi < N; gi++) begin : g_cmp
    assign eq[gi] = active[gi] && (vid_flat[gi*VID_W +: VID_W] == req_id);
  end

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (eq[i]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/vint_lr_prio_stack.sv
// Running-priority stack: push on acknowledge, pop on end-of-interrupt.
module vint_lr_prio_stack #(
  parameter int DEPTH = 16,
  parameter int PRI_W = 5,
  localparam int AW   = $clog2(DEPTH),
  localparam int SP_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [PRI_W-1:0] push_pri,
  input  logic             pop,
  output logic [PRI_W-1:0] rpr
);
  localparam logic [PRI_W-1:0] IDLE = '1;

  logic [PRI_W-1:0] stk [DEPTH];
  logic [SP_W-1:0]  sp;
  logic [SP_W-1:0]  below;

  assign below = sp - SP_W'(2);

  always_ff @(posedge clk) begin
    if (push && sp < SP_W'(DEPTH)) begin
      stk[sp[AW-1:0]] <= push_pri;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp  <= '0;
      rpr <= IDLE;
    end else if (push) begin
      if (sp < SP_W'(DEPTH)) begin
        sp  <= sp + SP_W'(1);
        rpr <= push_pri;
      end
    end else if (pop && sp != '0) begin
      sp  <= sp - SP_W'(1);
      rpr <= (sp >= SP_W'(2)) ? stk[below[AW-1:0]] : IDLE;
    end
  end
endmodule

// File: rtl/vint_lr_maint_timer.sv
// Holdoff counter gating the maintenance interrupt.
module vint_lr_maint_timer #(
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              any_done,
  input  logic [HOLD_W-1:0] holdoff,
  output logic              irq
);
  logic [HOLD_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !any_done) begin
      cnt <= '0;
      irq <= 1'b0;
    end else if (cnt >= holdoff) begin
      irq <= 1'b1;
    end else begin
      cnt <= cnt + HOLD_W'(1);
    end
  end
endmodule

// File: rtl/vint_lr_ctrl.sv
module vint_lr_ctrl #(
  parameter int N      = 16,
  parameter int PRI_W  = 5,
  parameter int VID_W  = 10,
  parameter int PID_W  = 10,
  parameter int HOLD_W = 8,
  localparam int IDX_W = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_split,
  input  logic [HOLD_W-1:0] cfg_holdoff,
  input  logic              hv_wr,
  input  logic [IDX_W-1:0]  hv_idx,
  input  logic [1:0]        hv_state,
  input  logic              hv_hw,
  input  logic              hv_maint,
  input  logic [PRI_W-1:0]  hv_pri,
  input  logic [VID_W-1:0]  hv_vid,
  input  logic [PID_W-1:0]  hv_pid,
  input  logic [IDX_W-1:0]  hv_rd_idx,
  output logic [1:0]        hv_rd_state,
  input  logic              g_ack,
  input  logic              g_eoi,
  input  logic              g_dir,
  input  logic [VID_W-1:0]  g_id,
  output logic              g_ack_vld,
  output logic [VID_W-1:0]  g_ack_id,
  output logic [PRI_W-1:0]  g_rpr,
  output logic [N-1:0]      eoi_status,
  output logic              maint_irq,
  output logic              pdeact_vld,
  output logic [PID_W-1:0]  pdeact_pid
);
  import vint_lr_pkg::*;

  localparam logic [VID_W-1:0] SPURIOUS = '1;

  lr_state_e        st_q  [N];
  logic             hw_q  [N];
  logic             mf_q  [N];
  logic [PRI_W-1:0] pri_q [N];
  logic [VID_W-1:0] vid_q [N];
  logic [PID_W-1:0] pid_q [N];

  logic [N-1:0]       elig;
  logic [N-1:0]       active;
  logic [N*PRI_W-1:0] pri_flat;
  logic [N*VID_W-1:0] vid_flat;

  for (genvar gi = 0; gi < N; gi++) begin : g_ent
    assign elig[gi]       = (st_q[gi] == ST_PEND) && (pri_q[gi] < g_rpr);
    assign active[gi]     = st_q[gi][1];
    assign eoi_status[gi] = (st_q[gi] == ST_INACT) && !hw_q[gi] && mf_q[gi];
    assign pri_flat[gi*PRI_W +: PRI_W] = pri_q[gi];
    assign vid_flat[gi*VID_W +: VID_W] = vid_q[gi];
  end

  logic             sel_found;
  logic [IDX_W-1:0] sel_idx;
  logic             m_hit;
  logic [IDX_W-1:0] m_idx;

  vint_lr_select #(.N(N), .PRI_W(PRI_W)) u_sel (
    .elig     (elig),
    .pri_flat (pri_flat),
    .found    (sel_found),
    .sel_idx  (sel_idx)
  );

  vint_lr_match #(.N(N), .VID_W(VID_W)) u_match (
    .active   (active),
    .vid_flat (vid_flat),
    .req_id   (g_id),
    .hit      (m_hit),
    .hit_idx  (m_idx)
  );

  // One guest operation per cycle: acknowledge, then end-of-interrupt, then deactivate.
  logic do_push, do_eoi, do_dir, do_deact;
  assign do_push  = g_ack && sel_found;
  assign do_eoi   = !g_ack && g_eoi && (g_id != SPURIOUS);
  assign do_dir   = !g_ack && !g_eoi && g_dir && cfg_split;
  assign do_deact = m_hit && ((do_eoi && !cfg_split) || do_dir);

  vint_lr_prio_stack #(.DEPTH(N), .PRI_W(PRI_W)) u_stack (
    .clk      (clk),
    .rst      (rst),
    .push     (do_push),
    .push_pri (pri_q[sel_idx]),
    .pop      (do_eoi),
    .rpr      (g_rpr)
  );

  vint_lr_maint_timer #(.HOLD_W(HOLD_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .any_done (|eoi_status),
    .holdoff  (cfg_holdoff),
    .irq      (maint_irq)
  );

  // Entry file and guest-visible result registers.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        st_q[i]  <= ST_INACT;
        hw_q[i]  <= 1'b0;
        mf_q[i]  <= 1'b0;
        pri_q[i] <= '0;
        vid_q[i] <= '0;
        pid_q[i] <= '0;
      end
      g_ack_vld   <= 1'b0;
      g_ack_id    <= '0;
      pdeact_vld  <= 1'b0;
      pdeact_pid  <= '0;
      hv_rd_state <= 2'b00;
    end else begin
      g_ack_vld   <= g_ack;
      hv_rd_state <= st_q[hv_rd_idx];
      if (g_ack) begin
        g_ack_id <= sel_found ? vid_q[sel_idx] : SPURIOUS;
      end
      if (do_push) begin
        st_q[sel_idx] <= ST_ACT;
      end
      pdeact_vld <= do_deact && hw_q[m_idx];
      if (do_deact) begin
        st_q[m_idx] <= lr_state_e'({1'b0, st_q[m_idx][0]});
        pdeact_pid  <= pid_q[m_idx];
      end
      if (hv_wr) begin
        st_q[hv_idx]  <= lr_state_e'(hv_state);
        hw_q[hv_idx]  <= hv_hw;
        mf_q[hv_idx]  <= hv_maint;
        pri_q[hv_idx] <= hv_pri;
        vid_q[hv_idx] <= hv_vid;
        pid_q[hv_idx] <= hv_pid;
      end
    end
  end
endmodule

// File: rtl/vint_lr_checker.sv
module vint_lr_checker #(
  parameter int N      = 16,
  parameter int PRI_W  = 5,
  parameter int VID_W  = 10,
  parameter int PID_W  = 10,
  parameter int HOLD_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_split,
  input logic [HOLD_W-1:0] cfg_holdoff,
  input logic              g_ack,
  input logic              g_eoi,
  input logic              g_dir,
  input logic              g_ack_vld,
  input logic [VID_W-1:0]  g_ack_id,
  input logic [PRI_W-1:0]  g_rpr,
  input logic [N-1:0]      eoi_status,
  input logic              maint_irq,
  input logic              pdeact_vld
);
  // R3: every acknowledge yields a result on the next cycle, and only then.
  a_r3_ack_result: assert property (@(posedge clk) disable iff (rst)
    g_ack |=> g_ack_vld);
  a_r3_ack_cause: assert property (@(posedge clk) disable iff (rst)
    g_ack_vld |-> $past(g_ack));
  // R4: a spurious answer leaves the running priority alone.
  a_r4_spurious_rpr: assert property (@(posedge clk) disable iff (rst)
    (g_ack_vld && g_ack_id == '1) |-> $stable(g_rpr));
  // R6: split-mode end-of-interrupt never retires a hardware-linked entry.
  a_r6_split_eoi_keeps: assert property (@(posedge clk) disable iff (rst)
    (cfg_split && g_eoi && !g_ack) |=> !pdeact_vld);
  // R8: a physical deactivate pulse follows a guest completion write.
  a_r8_pdeact_cause: assert property (@(posedge clk) disable iff (rst)
    pdeact_vld |-> $past(g_eoi || g_dir));
  // R9: the interrupt only follows a non-zero status vector.
  a_r9_maint_cause: assert property (@(posedge clk) disable iff (rst)
    maint_irq |-> $past(eoi_status != '0));
  // R9: zero holdoff reports at the next edge.
  a_r9_zero_holdoff: assert property (@(posedge clk) disable iff (rst)
    (cfg_holdoff == '0 && eoi_status != '0) |=> maint_irq);
  // R10: an empty vector clears the interrupt at the next edge.
  a_r10_maint_clears: assert property (@(posedge clk) disable iff (rst)
    (eoi_status == '0) |=> !maint_irq);
endmodule

bind vint_lr_ctrl vint_lr_checker #(
  .N(N), .PRI_W(PRI_W), .VID_W(VID_W), .PID_W(PID_W), .HOLD_W(HOLD_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_split   (cfg_split),
  .cfg_holdoff (cfg_holdoff),
  .g_ack       (g_ack),
  .g_eoi       (g_eoi),
  .g_dir       (g_dir),
  .g_ack_vld   (g_ack_vld),
  .g_ack_id    (g_ack_id),
  .g_rpr       (g_rpr),
  .eoi_status  (eoi_status),
  .maint_irq   (maint_irq),
  .pdeact_vld  (pdeact_vld)
);

// File: tb/tb_vint_lr_ctrl.sv
module tb_vint_lr_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16, PRI_W = 5, VID_W = 10, PID_W = 10, HOLD_W = 8;
  localparam int IDX_W = 4;
  localparam int WATCHDOG = 5000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_split = 1'b0;
  logic [HOLD_W-1:0] cfg_holdoff = '0;
  logic hv_wr = 1'b0;
  logic [IDX_W-1:0] hv_idx = '0, hv_rd_idx = '0;
  logic [1:0] hv_state = '0;
  logic hv_hw = 1'b0, hv_maint = 1'b0;
  logic [PRI_W-1:0] hv_pri = '0;
  logic [VID_W-1:0] hv_vid = '0, g_id = '0;
  logic [PID_W-1:0] hv_pid = '0;
  logic g_ack = 1'b0, g_eoi = 1'b0, g_dir = 1'b0;
  logic [1:0] hv_rd_state;
  logic g_ack_vld, maint_irq, pdeact_vld;
  logic [VID_W-1:0] g_ack_id;
  logic [PRI_W-1:0] g_rpr;
  logic [N-1:0] eoi_status;
  logic [PID_W-1:0] pdeact_pid;

  always #(CLK_PERIOD/2) clk = ~clk;

  vint_lr_ctrl dut (.*);

  int checks = 0, fails = 0, cyc = 0;

  // Reference model
  int m_st[N], m_hw[N], m_mf[N], m_pri[N], m_vid[N], m_pid[N];
  int m_stk[$];
  int m_cnt = 0, m_maint = 0, m_ackv = 0, m_ackid = 0, m_pdv = 0, m_pdpid = 0, m_rd = 0;

  function automatic int m_rpr();
    return (m_stk.size() == 0) ? 31 : m_stk[m_stk.size()-1];
  endfunction

  function automatic logic [N-1:0] m_eisr();
    logic [N-1:0] v = '0;
    for (int i = 0; i < N; i++) v[i] = (m_st[i] == 0 && m_hw[i] == 0 && m_mf[i] == 1);
    return v;
  endfunction

  task automatic m_retire(input int id);
    for (int i = 0; i < N; i++) begin
      if (m_st[i] >= 2 && m_vid[i] == id) begin
        m_st[i] -= 2;
        if (m_hw[i] == 1) begin m_pdv = 1; m_pdpid = m_pid[i]; end
        return;
      end
    end
  endtask

  task automatic model_step();
    int best, rp;
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        m_st[i] = 0; m_hw[i] = 0; m_mf[i] = 0; m_pri[i] = 0; m_vid[i] = 0; m_pid[i] = 0;
      end
      m_stk.delete();
      m_cnt = 0; m_maint = 0; m_ackv = 0; m_ackid = 0; m_pdv = 0; m_pdpid = 0; m_rd = 0;
      return;
    end
    m_rd = m_st[hv_rd_idx];
    if (m_eisr() == 0) begin m_cnt = 0; m_maint = 0; end
    else if (m_cnt >= cfg_holdoff) m_maint = 1;
    else m_cnt++;
    m_ackv = 0; m_pdv = 0;
    if (g_ack) begin
      best = -1; rp = m_rpr();
      for (int i = 0; i < N; i++)
        if (m_st[i] == 1 && m_pri[i] < rp && (best < 0 || m_pri[i] < m_pri[best])) best = i;
      m_ackv = 1;
      if (best >= 0) begin
        m_st[best] = 2; m_stk.push_back(m_pri[best]); m_ackid = m_vid[best];
      end else m_ackid = 1023;
    end else if (g_eoi && g_id != 1023) begin
      if (m_stk.size() > 0) void'(m_stk.pop_back());
      if (!cfg_split) m_retire(g_id);
    end else if (g_dir && cfg_split) begin
      m_retire(g_id);
    end
    if (hv_wr) begin
      m_st[hv_idx] = hv_state; m_hw[hv_idx] = hv_hw; m_mf[hv_idx] = hv_maint;
      m_pri[hv_idx] = hv_pri; m_vid[hv_idx] = hv_vid; m_pid[hv_idx] = hv_pid;
    end
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic compare();
    chk(eoi_status == m_eisr(), "R2 status vector", int'(eoi_status), int'(m_eisr()));
    chk(maint_irq == m_maint[0], "R9 maint_irq", int'(maint_irq), m_maint);
    chk(int'(g_rpr) == m_rpr(), "R5 running priority", int'(g_rpr), m_rpr());
    chk(g_ack_vld == m_ackv[0], "R3 ack valid", int'(g_ack_vld), m_ackv);
    if (m_ackv == 1) chk(int'(g_ack_id) == m_ackid, "R3 ack id", int'(g_ack_id), m_ackid);
    chk(pdeact_vld == m_pdv[0], "R8 pdeact valid", int'(pdeact_vld), m_pdv);
    if (m_pdv == 1) chk(int'(pdeact_pid) == m_pdpid, "R8 pdeact pid", int'(pdeact_pid), m_pdpid);
    chk(int'(hv_rd_state) == m_rd, "R11 read state", int'(hv_rd_state), m_rd);
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(input int idx, input int st, input int hw, input int mf,
                    input int pri, input int vid, input int pid);
    hv_wr = 1; hv_idx = IDX_W'(idx); hv_state = 2'(st); hv_hw = hw[0]; hv_maint = mf[0];
    hv_pri = PRI_W'(pri); hv_vid = VID_W'(vid); hv_pid = PID_W'(pid);
    tick();
    hv_wr = 0;
  endtask

  task automatic ack();
    g_ack = 1; tick(); g_ack = 0;
  endtask

  task automatic eoi(input int id);
    g_eoi = 1; g_id = VID_W'(id); tick(); g_eoi = 0;
  endtask

  task automatic dir(input int id);
    g_dir = 1; g_id = VID_W'(id); tick(); g_dir = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, WATCHDOG);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int n;
    @(negedge clk);
    idle(3);
    rst = 0;
    tick();
    // R1 reset state
    chk(eoi_status == '0 && !maint_irq && !g_ack_vld && !pdeact_vld, "R1 reset outputs",
        int'(eoi_status), 0);
    chk(g_rpr == 5'd31, "R1 idle priority", int'(g_rpr), 31);

    // Combined mode, holdoff 4
    cfg_holdoff = 8'd4;
    wr(0, 1, 0, 1, 8, 40, 0);
    wr(1, 1, 0, 1, 3, 41, 0);
    wr(2, 1, 0, 1, 3, 42, 0);
    wr(3, 1, 1, 1, 8, 43, 77);
    ack();
    chk(g_ack_id == 10'd41 && g_rpr == 5'd3, "R3 tie picks lowest index", int'(g_ack_id), 41);
    ack();
    chk(g_ack_id == 10'd1023, "R4 nothing eligible", int'(g_ack_id), 1023);
    eoi(41);
    chk(g_rpr == 5'd31 && eoi_status == 16'h0002, "R5 combined eoi", int'(eoi_status), 2);
    ack();
    eoi(42);
    chk(eoi_status == 16'h0006, "R10 two bits together", int'(eoi_status), 6);
    idle(4);
    chk(maint_irq && eoi_status == 16'h0006, "R10 maint reports both", int'(maint_irq), 1);
    wr(1, 0, 0, 0, 0, 0, 0);
    wr(2, 0, 0, 0, 0, 0, 0);
    tick();
    chk(!maint_irq, "R10 maint clears", int'(maint_irq), 0);
    ack();
    chk(g_ack_id == 10'd40 && g_rpr == 5'd8, "R3 equal priority lowest index", int'(g_ack_id), 40);
    eoi(1023);
    chk(g_rpr == 5'd8, "R7 spurious eoi ignored", int'(g_rpr), 8);
    dir(40);
    hv_rd_idx = 0;
    idle(2);
    chk(hv_rd_state == 2'b10, "R5 deactivate ignored in combined mode", int'(hv_rd_state), 2);
    eoi(40);
    chk(eoi_status == 16'h0001, "R2 bit set on retire", int'(eoi_status), 1);
    wr(0, 0, 0, 0, 0, 0, 0);

    // Split mode
    cfg_split = 1;
    ack();
    chk(g_ack_id == 10'd43, "R3 ack hw entry", int'(g_ack_id), 43);
    eoi(43);
    hv_rd_idx = 3;
    idle(2);
    chk(g_rpr == 5'd31 && hv_rd_state == 2'b10, "R6 split eoi keeps entry active",
        int'(hv_rd_state), 2);
    dir(43);
    chk(pdeact_vld && pdeact_pid == 10'd77, "R8 physical pulse", int'(pdeact_pid), 77);
    chk(eoi_status == '0, "R8 no status for hw entry", int'(eoi_status), 0);
    tick();
    chk(!pdeact_vld, "R8 single-cycle pulse", int'(pdeact_vld), 0);

    // Holdoff 3: rises on fourth edge
    cfg_holdoff = 8'd3;
    wr(4, 1, 0, 1, 5, 50, 0);
    ack(); eoi(50); dir(50);
    n = 0;
    while (!maint_irq && n < 20) begin tick(); n++; end
    chk(n == 4, "R9 holdoff 3 edges to irq", n, 4);
    wr(4, 0, 0, 0, 0, 0, 0);

    // Holdoff 0: next edge
    cfg_holdoff = 8'd0;
    wr(5, 1, 0, 1, 4, 51, 0);
    ack(); eoi(51); dir(51);
    chk(!maint_irq, "R9 not on retiring edge", int'(maint_irq), 0);
    tick();
    chk(maint_irq, "R9 zero holdoff", int'(maint_irq), 1);
    wr(5, 0, 0, 0, 0, 0, 0);

    // Several EOIs, then sequential deactivations
    cfg_holdoff = 8'd10;
    wr(6, 1, 0, 1, 6, 60, 0);
    wr(7, 1, 0, 1, 7, 61, 0);
    ack(); eoi(60); ack(); eoi(61);
    dir(60);
    chk(eoi_status == 16'h0040, "R6 first deactivate", int'(eoi_status), 64);
    dir(61);
    chk(eoi_status == 16'h00C0 && !maint_irq, "R6 sequential deactivates", int'(eoi_status), 192);
    idle(12);
    chk(maint_irq, "R10 batched report", int'(maint_irq), 1);
    wr(6, 0, 0, 0, 0, 0, 0);
    wr(7, 0, 0, 0, 0, 0, 0);

    // Read-back after write
    wr(8, 1, 0, 0, 9, 70, 0);
    hv_rd_idx = 8;
    tick();
    chk(hv_rd_state == 2'b01, "R11 read back", int'(hv_rd_state), 1);
    idle(3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule